// File: doc/BRIEF.md
# I2C Multi-Source Slave Address Matcher

This block decides, during the address phase of an I2C transfer, whether the device is being addressed as a slave. It compares the received address byte or bytes against up to four address sources at once:

- a primary own address, which is always active;
- a second own address, with its own enable;
- the general call address, with its own enable;
- the SMBus alert response address, with its own enable.

It then raises an addressed flag, reports which source won in a one-hot vector, and issues an ACK decision for each address byte. A bus front end supplies decoded START/STOP pulses and complete received bytes. Data-phase handling, clock stretching and master operation belong to other blocks.

A mode input selects 7-bit or 10-bit own addresses. In 10-bit mode the first byte carries a fixed tag and the two upper address bits. That byte is acknowledged without declaring a hit, and the second byte settles the match. The general call and alert response addresses are 7-bit reserved codes and are matched on the first byte in either mode. The first received address byte is kept on an output until the next address phase, so software can inspect it after the transfer.

Top module: `i2c_addr_matcher`

## Requirements
- R1: The primary address always takes part in matching, whatever the enable inputs are. In 7-bit mode a first byte whose bits [7:1] equal own_addr1[6:0] sets `addressed`, sets hit_vec bit 0 and answers ack=1. The R/W bit (bit 0) is never compared.
- R2: The second address matches only while addr2_en=1, using the same rule as R1 applied to own_addr2 and reporting on hit_vec bit 1. While addr2_en=0 that byte gives ack=0 and leaves `addressed` low.
- R3: The general call code 7'b0000000 in bits [7:1] matches only while gc_en=1, in both 7-bit and 10-bit mode, and reports on hit_vec bit 2.
- R4: The alert response code 7'b0001100 in bits [7:1] matches only while alert_en=1, in both modes, and reports on hit_vec bit 3.
- R5: When several enabled sources match the same byte, hit_vec is one-hot and shows the winner. Priority runs primary (bit 0), then second (bit 1), then general call (bit 2), then alert (bit 3). `addressed` is 1 exactly when hit_vec is non-zero.
- R6: In 10-bit mode (mode_10b=1), own addresses are matched over two bytes:
  - The first byte must have bits [7:3]=5'b11110 and bits [2:1] equal to the address bits [9:8] of an enabled own source. Such a byte is answered ack=1 while `addressed` stays 0.
  - The second byte must then equal address bits [7:0] of that source for a hit.
  - A mismatch on either byte gives ack=0 and no hit.
  - 7-bit comparison of own addresses is off in this mode.
- R7: Each address byte, meaning the first byte after a START and the second byte of a pending 10-bit match, produces a one-cycle ack_valid pulse in the cycle after byte_valid, with the decision on ack. Bytes after the address phase, or with no START since reset or STOP, produce no pulse and leave `addressed` and hit_vec unchanged.
- R8: A STOP clears `addressed` and hit_vec in the next cycle.
- R9: A repeated START followed by a non-matching address byte clears `addressed` and hit_vec. A matching one replaces hit_vec with the new winner.
- R10: first_byte holds the first address byte of the latest address phase. It keeps that value through STOP until the first byte after the next START, and in 10-bit mode it shows the tag byte, not the low byte.
- R11: After reset, `addressed`, hit_vec, ack_valid, ack and first_byte are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_det | input | 1 | One-cycle pulse for START or repeated START |
| stop_det | input | 1 | One-cycle pulse for STOP |
| byte_valid | input | 1 | One-cycle pulse: rx_byte holds a complete received byte |
| rx_byte | input | 8 | Received byte, bit 0 being the R/W bit on address bytes |
| mode_10b | input | 1 | 1 selects 10-bit own addresses, 0 selects 7-bit |
| own_addr1 | input | 10 | Primary own address (bits [6:0] used in 7-bit mode) |
| own_addr2 | input | 10 | Second own address |
| addr2_en | input | 1 | Enables the second address |
| gc_en | input | 1 | Enables general call matching |
| alert_en | input | 1 | Enables alert response matching |
| addressed | output | 1 | Addressed-as-slave flag |
| hit_vec | output | 4 | One-hot winning source: bit0 primary, bit1 second, bit2 general call, bit3 alert |
| ack_valid | output | 1 | One-cycle pulse marking an ACK decision |
| ack | output | 1 | ACK decision, valid with ack_valid |
| first_byte | output | 8 | First address byte of the latest address phase |

## Verification
The bench aims at overlapping matches: two own addresses set equal, and a general call or alert code that equals an own address. A wrong priority encoder would show two bits or the wrong bit in hit_vec. It runs the 10-bit two-byte sequence with a correct tag and a wrong low byte, a wrong upper pair, and a 7-bit-looking byte in 10-bit mode. A design that declared the hit on the tag byte, or kept 7-bit comparison alive, would raise `addressed` early or acknowledge the wrong byte. Data bytes after a hit, repeated STARTs with missing addresses, and STOP are sent to catch a flag that sticks or is recomputed from data. first_byte is read after STOP to catch a capture register that is cleared or overwritten by the low byte.

// File: rtl/i2cam_pkg.sv
package i2cam_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR7_W   = 7;
  localparam int ADDR10_W  = 10;
  localparam int NUM_SRC   = 4;
  localparam int SRC_PRI   = 0;
  localparam int SRC_SEC   = 1;
  localparam int SRC_GC    = 2;
  localparam int SRC_ALR   = 3;

  localparam logic [ADDR7_W-1:0] GC_CODE    = 7'b0000000;
  localparam logic [ADDR7_W-1:0] ALERT_CODE = 7'b0001100;
  localparam logic [4:0]         TAG10      = 5'b11110;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2,
    PH_DATA   = 2'd3
  } phase_e;

  // 7-bit compare: R/W bit excluded
  function automatic logic cmp7(input logic [BYTE_W-1:0] b,
                                input logic [ADDR7_W-1:0] a);
    return b[BYTE_W-1:1] == a;
  endfunction

  // 10-bit first byte: tag plus upper address pair, R/W excluded
  function automatic logic cmp10_hi(input logic [BYTE_W-1:0] b,
                                    input logic [1:0] hi);
    return (b[7:3] == TAG10) && (b[2:1] == hi);
  endfunction

  // keep lowest set bit: lowest index has highest priority
  function automatic src_vec_t pick_winner(input src_vec_t v);
    return v & (~v + src_vec_t'(1));
  endfunction
endpackage

// File: rtl/i2cam_src_cmp.sv
module i2cam_src_cmp
  import i2cam_pkg::*;
(
  input  logic [BYTE_W-1:0]   rx_byte,
  input  logic [ADDR10_W-1:0] ref_addr,
  input  logic                is_fixed,
  input  logic                mode_10b,
  input  logic                enable,
  output logic                hit_first,
  output logic                cand_hi,
  output logic                hit_low
);
  logic own10;
  assign own10 = enable & ~is_fixed & mode_10b;

  // fixed codes are 7-bit in either mode; own addresses only in 7-bit mode
  assign hit_first = enable & (is_fixed | ~mode_10b) &
                     cmp7(rx_byte, ref_addr[ADDR7_W-1:0]);
  assign cand_hi   = own10 & cmp10_hi(rx_byte, ref_addr[9:8]);
  assign hit_low   = own10 & (rx_byte == ref_addr[7:0]);
endmodule

// File: rtl/i2cam_phase.sv
module i2cam_phase
  import i2cam_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_det,
  input  logic stop_det,
  input  logic byte_valid,
  input  logic go_second,
  output logic dec_first,
  output logic dec_second
);
  phase_e phase_q, phase_d;
  logic   bus_evt;

  assign bus_evt    = start_det | stop_det;
  assign dec_first  = byte_valid & ~bus_evt & (phase_q == PH_FIRST);
  assign dec_second = byte_valid & ~bus_evt & (phase_q == PH_SECOND);

  always_comb begin
    phase_d = phase_q;
    if (stop_det)        phase_d = PH_IDLE;
    else if (start_det)  phase_d = PH_FIRST;
    else if (dec_first)  phase_d = go_second ? PH_SECOND : PH_DATA;
    else if (dec_second) phase_d = PH_DATA;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (phase_q == PH_IDLE));

  assert_one_decision_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_first && dec_second));

  assert_data_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DATA && !start_det) |=> !dec_first && !dec_second);
endmodule

// File: rtl/i2cam_result.sv
module i2cam_result
  import i2cam_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_det,
  input  logic              dec_first,
  input  logic              dec_second,
  input  logic              go_second,
  input  logic [BYTE_W-1:0] rx_byte,
  input  src_vec_t          hit_first_v,
  input  src_vec_t          cand_v,
  input  src_vec_t          hit_low_v,
  output logic              addressed,
  output src_vec_t          hit_vec,
  output logic              ack_valid,
  output logic              ack,
  output logic [BYTE_W-1:0] first_byte
);
  src_vec_t cand_q;
  src_vec_t low_hits;
  src_vec_t win_first, win_second;

  assign low_hits   = cand_q & hit_low_v;
  assign win_first  = pick_winner(hit_first_v);
  assign win_second = pick_winner(low_hits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addressed  <= 1'b0;
      hit_vec    <= '0;
      ack_valid  <= 1'b0;
      ack        <= 1'b0;
      first_byte <= '0;
      cand_q     <= '0;
    end else begin
      ack_valid <= 1'b0;
      if (stop_det) begin
        addressed <= 1'b0;
        hit_vec   <= '0;
      end else if (dec_first) begin
        first_byte <= rx_byte;
        cand_q     <= cand_v;
        hit_vec    <= win_first;
        addressed  <= |hit_first_v;
        ack_valid  <= 1'b1;
        ack        <= (|hit_first_v) | go_second;
      end else if (dec_second) begin
        hit_vec   <= win_second;
        addressed <= |low_hits;
        ack_valid <= 1'b1;
        ack       <= |low_hits;
      end
    end
  end

  assert_onehot_hits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_flag_tracks_vec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    addressed == (hit_vec != '0));

  assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !addressed && (hit_vec == '0));

  assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(dec_first || dec_second));

  assert_hit_means_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && addressed) |-> ack);
endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
  import i2cam_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_det,
  input  logic        stop_det,
  input  logic        byte_valid,
  input  logic [7:0]  rx_byte,
  input  logic        mode_10b,
  input  logic [9:0]  own_addr1,
  input  logic [9:0]  own_addr2,
  input  logic        addr2_en,
  input  logic        gc_en,
  input  logic        alert_en,
  output logic        addressed,
  output logic [3:0]  hit_vec,
  output logic        ack_valid,
  output logic        ack,
  output logic [7:0]  first_byte
);
  logic [ADDR10_W-1:0] ref_addr [NUM_SRC];
  src_vec_t src_en, src_fixed;
  src_vec_t hit_first_v, cand_v, hit_low_v;
  logic     go_second, dec_first, dec_second;

  always_comb begin
    ref_addr[SRC_PRI]  = own_addr1;
    ref_addr[SRC_SEC]  = own_addr2;
    ref_addr[SRC_GC]   = {3'b000, GC_CODE};
    ref_addr[SRC_ALR]  = {3'b000, ALERT_CODE};
    src_en             = '0;
    src_en[SRC_PRI]    = 1'b1;
    src_en[SRC_SEC]    = addr2_en;
    src_en[SRC_GC]     = gc_en;
    src_en[SRC_ALR]    = alert_en;
    src_fixed          = '0;
    src_fixed[SRC_GC]  = 1'b1;
    src_fixed[SRC_ALR] = 1'b1;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    i2cam_src_cmp u_cmp (
      .rx_byte   (rx_byte),
      .ref_addr  (ref_addr[i]),
      .is_fixed  (src_fixed[i]),
      .mode_10b  (mode_10b),
      .enable    (src_en[i]),
      .hit_first (hit_first_v[i]),
      .cand_hi   (cand_v[i]),
      .hit_low   (hit_low_v[i])
    );
  end

  assign go_second = mode_10b & (|cand_v) & ~(|hit_first_v);

  i2cam_phase u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .byte_valid (byte_valid),
    .go_second  (go_second),
    .dec_first  (dec_first),
    .dec_second (dec_second)
  );

  i2cam_result u_result (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_det    (stop_det),
    .dec_first   (dec_first),
    .dec_second  (dec_second),
    .go_second   (go_second),
    .rx_byte     (rx_byte),
    .hit_first_v (hit_first_v),
    .cand_v      (cand_v),
    .hit_low_v   (hit_low_v),
    .addressed   (addressed),
    .hit_vec     (hit_vec),
    .ack_valid   (ack_valid),
    .ack         (ack),
    .first_byte  (first_byte)
  );

  assert_primary_always_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_first && !mode_10b && rx_byte[7:1] == own_addr1[6:0])
      |=> addressed && hit_vec[SRC_PRI] && ack);

  assert_tenbit_defer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_first && go_second) |=> !addressed && ack && ack_valid);

  assert_gc_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_first && !gc_en) |=> !hit_vec[SRC_GC]);

  assert_alert_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_first && !alert_en) |=> !hit_vec[SRC_ALR]);
endmodule

// File: tb/i2c_addr_matcher_tb_top.sv
module i2c_addr_matcher_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_det = 1'b0, stop_det = 1'b0, byte_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       mode_10b = 1'b0;
  logic [9:0] own_addr1 = '0, own_addr2 = '0;
  logic       addr2_en = 1'b0, gc_en = 1'b0, alert_en = 1'b0;
  logic       addressed, ack_valid, ack;
  logic [3:0] hit_vec;
  logic [7:0] first_byte;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  i2c_addr_matcher dut_i (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
    .byte_valid(byte_valid), .rx_byte(rx_byte), .mode_10b(mode_10b),
    .own_addr1(own_addr1), .own_addr2(own_addr2), .addr2_en(addr2_en),
    .gc_en(gc_en), .alert_en(alert_en), .addressed(addressed),
    .hit_vec(hit_vec), .ack_valid(ack_valid), .ack(ack), .first_byte(first_byte)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) start_det = 1'b1;
    @(negedge clk) start_det = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk) stop_det = 1'b1;
    @(negedge clk) stop_det = 1'b0;
  endtask

  // drives one byte; returns at the negedge where the decision is visible
  task automatic send(input logic [7:0] b);
    @(negedge clk) begin rx_byte = b; byte_valid = 1'b1; end
    @(negedge clk) byte_valid = 1'b0;
  endtask

  // model for a 7-bit first byte: scan from lowest priority up so the best one sticks
  function automatic logic [3:0] model7(input logic [7:0] b);
    logic [6:0] codes [4];
    logic [3:0] ens;
    logic [3:0] res = '0;
    codes[0] = own_addr1[6:0]; codes[1] = own_addr2[6:0];
    codes[2] = 7'h00;          codes[3] = 7'h0C;
    ens = {alert_en, gc_en, addr2_en, 1'b1};
    for (int k = 3; k >= 0; k--) begin
      if (ens[k] && (k >= 2 || !mode_10b) && (b >> 1) == {1'b0, codes[k]})
        res = 4'b0001 << k;
    end
    return res;
  endfunction

  task automatic expect_first(input string req, input logic [7:0] b);
    logic [3:0] e;
    e = model7(b);
    send(b);
    chk({req, " ack_valid"}, ack_valid, 1);
    chk({req, " ack"}, ack, e != 0);
    chk({req, " hit_vec"}, hit_vec, e);
    chk({req, " addressed"}, addressed, e != 0);
  endtask

  task automatic set_cfg(input logic m, input logic [9:0] a1, input logic [9:0] a2,
                         input logic e2, input logic eg, input logic ea);
    mode_10b = m; own_addr1 = a1; own_addr2 = a2;
    addr2_en = e2; gc_en = eg; alert_en = ea;
  endtask

  task automatic t_reset_r11();
    chk("R11 addressed", addressed, 0);
    chk("R11 hit_vec", hit_vec, 0);
    chk("R11 ack_valid", ack_valid, 0);
    chk("R11 ack", ack, 0);
    chk("R11 first_byte", first_byte, 0);
    send(8'hA4);  // no START yet: ignored (R7)
    chk("R7 no start ack_valid", ack_valid, 0);
    chk("R7 no start addressed", addressed, 0);
  endtask

  task automatic t_primary_r1();
    set_cfg(0, 10'h052, 10'h033, 0, 0, 0);
    do_start(); expect_first("R1 write", 8'hA4);
    do_start(); expect_first("R1 read", 8'hA5);
    do_start(); expect_first("R1 miss", 8'hA6);
    chk("R1 miss flag", addressed, 0);
  endtask

  task automatic t_second_r2();
    set_cfg(0, 10'h052, 10'h033, 0, 0, 0);
    do_start(); expect_first("R2 disabled", 8'h66);
    chk("R2 disabled ack", ack, 0);
    addr2_en = 1;
    do_start(); expect_first("R2 enabled", 8'h66);
    chk("R2 enabled vec", hit_vec, 4'b0010);
  endtask

  task automatic t_gc_r3();
    set_cfg(0, 10'h052, 10'h033, 0, 0, 0);
    do_start(); expect_first("R3 disabled", 8'h00);
    chk("R3 disabled flag", addressed, 0);
    gc_en = 1;
    do_start(); expect_first("R3 enabled", 8'h01);
    chk("R3 enabled vec", hit_vec, 4'b0100);
    mode_10b = 1;
    do_start(); send(8'h00);
    chk("R3 in 10-bit vec", hit_vec, 4'b0100);
  endtask

  task automatic t_alert_r4();
    set_cfg(0, 10'h052, 10'h033, 0, 0, 0);
    do_start(); expect_first("R4 disabled", 8'h19);
    chk("R4 disabled flag", addressed, 0);
    alert_en = 1;
    do_start(); expect_first("R4 enabled", 8'h19);
    chk("R4 enabled vec", hit_vec, 4'b1000);
  endtask

  task automatic t_priority_r5();
    set_cfg(0, 10'h052, 10'h052, 1, 1, 1);
    do_start(); expect_first("R5 pri over sec", 8'hA4);
    chk("R5 pri over sec vec", hit_vec, 4'b0001);
    set_cfg(0, 10'h000, 10'h000, 1, 1, 1);
    do_start(); expect_first("R5 pri over gc", 8'h00);
    chk("R5 pri over gc vec", hit_vec, 4'b0001);
    set_cfg(0, 10'h052, 10'h00C, 1, 1, 1);
    do_start(); expect_first("R5 sec over alert", 8'h18);
    chk("R5 sec over alert vec", hit_vec, 4'b0010);
  endtask

  task automatic t_tenbit_r6();
    set_cfg(1, 10'h2A5, 10'h1C3, 0, 0, 0);
    do_start(); send(8'hF4);
    chk("R6 tag ack", ack, 1);
    chk("R6 tag ack_valid", ack_valid, 1);
    chk("R6 tag no flag", addressed, 0);
    send(8'hA5);
    chk("R6 low ack", ack, 1);
    chk("R6 low flag", addressed, 1);
    chk("R6 low vec", hit_vec, 4'b0001);
    chk("R10 tag kept", first_byte, 8'hF4);
    do_start(); send(8'hF4); send(8'hA6);
    chk("R6 bad low ack", ack, 0);
    chk("R6 bad low flag", addressed, 0);
    do_start(); send(8'hF2);
    chk("R6 sec disabled ack", ack, 0);
    addr2_en = 1;
    do_start(); send(8'hF2); send(8'hC3);
    chk("R6 second src vec", hit_vec, 4'b0010);
    do_start(); send(8'h4A);
    chk("R6 7-bit off ack", ack, 0);
    chk("R6 7-bit off flag", addressed, 0);
  endtask

  task automatic t_data_r7();
    set_cfg(0, 10'h052, 10'h033, 0, 1, 0);
    do_start(); expect_first("R7 addr", 8'hA4);
    send(8'h00);
    chk("R7 data no pulse", ack_valid, 0);
    chk("R7 data flag kept", addressed, 1);
    chk("R7 data vec kept", hit_vec, 4'b0001);
    chk("R7 data first_byte kept", first_byte, 8'hA4);
  endtask

  task automatic t_stop_r8_r10();
    set_cfg(0, 10'h052, 10'h033, 0, 0, 0);
    do_start(); expect_first("R8 addr", 8'hA4);
    do_stop();
    chk("R8 flag cleared", addressed, 0);
    chk("R8 vec cleared", hit_vec, 0);
    chk("R10 kept after stop", first_byte, 8'hA4);
    send(8'hA4);
    chk("R7 after stop ignored", addressed, 0);
  endtask

  task automatic t_restart_r9();
    set_cfg(0, 10'h052, 10'h033, 0, 1, 0);
    do_start(); expect_first("R9 first", 8'hA4);
    do_start(); expect_first("R9 miss", 8'h7E);
    chk("R9 miss clears", addressed, 0);
    do_start(); expect_first("R9 new", 8'h00);
    chk("R9 new vec", hit_vec, 4'b0100);
    chk("R10 updated", first_byte, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r11();
    t_primary_r1();
    t_second_r2();
    t_gc_r3();
    t_alert_r4();
    t_priority_r5();
    t_tenbit_r6();
    t_data_r7();
    t_stop_r8_r10();
    t_restart_r9();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule